// File: doc/BRIEF.md
# User-Defined Glyph RAM Controller

This block holds sixteen host-defined 5×7 dot-matrix character patterns for an alphanumeric display. A host reaches it over a small parallel bus: an 8-bit data path, a 5-bit address, a register-select line and active-low chip-enable, write and read strobes. Loading a glyph is indirect. The host first writes a slot number into a glyph index register. It then writes the seven rows of that slot one at a time. The low three address bits pick the row, and the low five data bits carry the dots, right-justified.

A second, read-only port serves the display scan logic. It takes a slot number and a row code and returns that row's five dots one clock later, with no arbitration against the host. All bus inputs are registered on entry. Each write strobe acts once, when its assertion is first seen, so holding the strobe low writes only once.

Top module: `glyph_ram_ctrl`

## Requirements
- R1: Reset (rst_n low) clears the glyph index to 0 and drives rdata and scan_dots to 0.
- R2: Reset leaves the stored row patterns unchanged.
- R3: With sel_reg high and addr[4:3]=00, a write stores wdata[3:0] as the glyph index and ignores wdata[7:4]. A read returns the index in rdata[3:0] with rdata[7:4]=0.
- R4: A write or read with sel_reg low, or with addr[4:3] equal to 10 or 11, changes no state and returns rdata=0.
- R5: With sel_reg high and addr[4:3]=01, a write stores wdata[4:0] into row addr[2:0] (000 = first row, 110 = seventh row) of the slot held in the index, ignoring wdata[7:5]. A read returns that row in rdata[4:0] with rdata[7:5]=0.
- R6: Row code 111 writes nothing and reads back 0.
- R7: When ce_n, wr_n and rd_n are all low together, nothing is written and rdata is 0.
- R8: A write happens once per assertion of the write strobe (ce_n and wr_n both low). Changing wdata while the strobe stays low writes nothing more.
- R9: rdata is 0 in every cycle that follows a cycle with no read strobe (ce_n or rd_n high).
- R10: scan_dots shows row scan_row of slot scan_glyph one clock after they are presented. Row code 111 gives 0.
- R11: The scan port ignores the host bus. A write that lands on the same clock edge as the scan sample is seen on the next edge.
- R12: Bus inputs are registered on entry. rdata shows a read's result after the second rising edge following the inputs, and a write takes effect on that same second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| sel_reg | input | 1 | Register-select; must be high for this block to respond |
| addr | input | 5 | Bus address: [4:3] target, [2:0] row code |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, zero when not reading |
| scan_glyph | input | 4 | Scan port slot number |
| scan_row | input | 3 | Scan port row code |
| scan_dots | output | 5 | Scan port row pattern, bit 0 = rightmost column |

## Verification
Some properties are checked on every cycle. rdata never shows anything above the five dot bits. rdata is zero after a cycle with no read strobe or with conflicting strobes. The unused row code yields zero on the scan port. scan_dots holds steady while its inputs and the write strobe are quiet. The bench scenarios cover the rest. These are index-then-row writes reaching the right slot, data bits being discarded, undecoded codes and conflicting strobes leaving storage untouched, a held strobe writing only once, retention across reset, and the one-edge visibility of a write that coincides with a scan sample.

// File: rtl/glyph_pkg.sv
package glyph_pkg;

   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_INDEX = 2'd1,
      TGT_ROW   = 2'd2
   } glyph_tgt_e;

   localparam logic [1:0] CODE_INDEX = 2'b00;
   localparam logic [1:0] CODE_ROW   = 2'b01;

endpackage

// File: rtl/glyph_bus_sync.sv
module glyph_bus_sync #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic              sel_reg,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              sel_s,
   output logic [ADDR_W-1:0] addr_s,
   output logic [DATA_W-1:0] wdata_s,
   output logic              wr_fire,
   output logic              rd_act
);

   logic ce_n_s, wr_n_s, rd_n_s;
   logic wstb_q;
   logic wstb, rstb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ce_n_s  <= 1'b1;
         wr_n_s  <= 1'b1;
         rd_n_s  <= 1'b1;
         sel_s   <= 1'b0;
         addr_s  <= '0;
         wdata_s <= '0;
         wstb_q  <= 1'b0;
      end else begin
         ce_n_s  <= ce_n;
         wr_n_s  <= wr_n;
         rd_n_s  <= rd_n;
         sel_s   <= sel_reg;
         addr_s  <= addr;
         wdata_s <= wdata;
         wstb_q  <= wstb;
      end
   end

   assign wstb    = ~ce_n_s & ~wr_n_s;
   assign rstb    = ~ce_n_s & ~rd_n_s;
   // act once on the first sampled cycle of a write strobe; a clash with read blocks it
   assign wr_fire = wstb & ~wstb_q & ~rstb;
   assign rd_act  = rstb & ~wstb;

endmodule

// File: rtl/glyph_decode.sv
module glyph_decode
   import glyph_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int ROW_SEL_W = 3
) (
   input  logic                 sel_s,
   input  logic [ADDR_W-1:0]    addr_s,
   output glyph_tgt_e           tgt,
   output logic [ROW_SEL_W-1:0] row
);

   localparam int TGT_W = ADDR_W - ROW_SEL_W;

   generate
      if (TGT_W != 2) begin : g_bad_split
         $error("glyph_decode: address must leave exactly two target bits");
      end
   endgenerate

   logic [1:0] code;
   assign code = addr_s[ADDR_W-1 -: 2];
   assign row  = addr_s[ROW_SEL_W-1:0];

   always_comb begin
      tgt = TGT_NONE;
      if (sel_s) begin
         unique case (code)
            CODE_INDEX: tgt = TGT_INDEX;
            CODE_ROW:   tgt = TGT_ROW;
            default:    tgt = TGT_NONE;
         endcase
      end
   end

endmodule

// File: rtl/glyph_store.sv
module glyph_store #(
   parameter int SLOTS     = 16,
   parameter int ROWS      = 7,
   parameter int COLS      = 5,
   parameter int ROW_SEL_W = 3,
   localparam int IDX_W    = $clog2(SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_slot,
   input  logic [ROW_SEL_W-1:0] wr_row,
   input  logic [COLS-1:0]      wr_dots,
   input  logic [IDX_W-1:0]     hr_slot,
   input  logic [ROW_SEL_W-1:0] hr_row,
   output logic [COLS-1:0]      hr_dots,
   input  logic [IDX_W-1:0]     sc_slot,
   input  logic [ROW_SEL_W-1:0] sc_row,
   output logic [COLS-1:0]      sc_dots
);

   localparam logic [ROW_SEL_W-1:0] ROW_LIM = ROW_SEL_W'(ROWS);

   generate
      if (ROWS >= (1 << ROW_SEL_W)) begin : g_bad_rows
         $error("glyph_store: row code space must keep one unused code");
      end
      if ((1 << IDX_W) != SLOTS) begin : g_bad_slots
         $error("glyph_store: slot count must be a power of two");
      end
   endgenerate

   logic [COLS-1:0] mem [SLOTS][ROWS];
   logic            wr_ok, hr_ok, sc_ok;

   assign wr_ok = wr_en && (wr_row < ROW_LIM);
   assign hr_ok = hr_row < ROW_LIM;
   assign sc_ok = sc_row < ROW_LIM;

   // storage carries no reset: patterns survive a reset pulse
   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_slot][wr_row] <= wr_dots;
   end

   assign hr_dots = hr_ok ? mem[hr_slot][hr_row] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)     sc_dots <= '0;
      else if (sc_ok) sc_dots <= mem[sc_slot][sc_row];
      else            sc_dots <= '0;
   end

endmodule

// File: rtl/glyph_ram_ctrl.sv
module glyph_ram_ctrl
   import glyph_pkg::*;
#(
   parameter int SLOTS     = 16,
   parameter int ROWS      = 7,
   parameter int COLS      = 5,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 5,
   parameter int ROW_SEL_W = 3,
   localparam int IDX_W    = $clog2(SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ce_n,
   input  logic                 wr_n,
   input  logic                 rd_n,
   input  logic                 sel_reg,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   input  logic [IDX_W-1:0]     scan_glyph,
   input  logic [ROW_SEL_W-1:0] scan_row,
   output logic [COLS-1:0]      scan_dots
);

   localparam int DOT_PAD = DATA_W - COLS;
   localparam int IDX_PAD = DATA_W - IDX_W;

   generate
      if (COLS > DATA_W) begin : g_bad_cols
         $error("glyph_ram_ctrl: row wider than data bus");
      end
      if (IDX_W > DATA_W) begin : g_bad_idx
         $error("glyph_ram_ctrl: index wider than data bus");
      end
   endgenerate

   logic                 sel_s;
   logic [ADDR_W-1:0]    addr_s;
   logic [DATA_W-1:0]    wdata_s;
   logic                 wr_fire, rd_act;
   glyph_tgt_e           tgt;
   logic [ROW_SEL_W-1:0] row;
   logic [IDX_W-1:0]     idx_q;
   logic [COLS-1:0]      host_dots;
   logic [DATA_W-1:0]    rdata_d;

   glyph_bus_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_n    (ce_n),
      .wr_n    (wr_n),
      .rd_n    (rd_n),
      .sel_reg (sel_reg),
      .addr    (addr),
      .wdata   (wdata),
      .sel_s   (sel_s),
      .addr_s  (addr_s),
      .wdata_s (wdata_s),
      .wr_fire (wr_fire),
      .rd_act  (rd_act)
   );

   glyph_decode #(.ADDR_W(ADDR_W), .ROW_SEL_W(ROW_SEL_W)) u_dec (
      .sel_s  (sel_s),
      .addr_s (addr_s),
      .tgt    (tgt),
      .row    (row)
   );

   glyph_store #(
      .SLOTS(SLOTS), .ROWS(ROWS), .COLS(COLS), .ROW_SEL_W(ROW_SEL_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_fire && (tgt == TGT_ROW)),
      .wr_slot (idx_q),
      .wr_row  (row),
      .wr_dots (wdata_s[COLS-1:0]),
      .hr_slot (idx_q),
      .hr_row  (row),
      .hr_dots (host_dots),
      .sc_slot (scan_glyph),
      .sc_row  (scan_row),
      .sc_dots (scan_dots)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                            idx_q <= '0;
      else if (wr_fire && tgt == TGT_INDEX)  idx_q <= wdata_s[IDX_W-1:0];
   end

   always_comb begin
      rdata_d = '0;
      if (rd_act) begin
         case (tgt)
            TGT_INDEX: rdata_d = {{IDX_PAD{1'b0}}, idx_q};
            TGT_ROW:   rdata_d = {{DOT_PAD{1'b0}}, host_dots};
            default:   rdata_d = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= rdata_d;
   end

endmodule

// File: rtl/glyph_ram_ctrl_chk.sv
module glyph_ram_ctrl_chk #(
   parameter int SLOTS     = 16,
   parameter int ROWS      = 7,
   parameter int COLS      = 5,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 5,
   parameter int ROW_SEL_W = 3,
   localparam int IDX_W    = $clog2(SLOTS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ce_n,
   input logic                 wr_n,
   input logic                 rd_n,
   input logic                 sel_reg,
   input logic [ADDR_W-1:0]    addr,
   input logic [DATA_W-1:0]    wdata,
   input logic [DATA_W-1:0]    rdata,
   input logic [IDX_W-1:0]     scan_glyph,
   input logic [ROW_SEL_W-1:0] scan_row,
   input logic [COLS-1:0]      scan_dots
);

   localparam logic [ROW_SEL_W-1:0] ROW_LIM = ROW_SEL_W'(ROWS);

   logic       clash_q, noread_q;
   logic [1:0] quiet_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clash_q   <= 1'b0;
         noread_q  <= 1'b0;
         quiet_cnt <= '0;
      end else begin
         clash_q  <= ~ce_n & ~wr_n & ~rd_n;
         noread_q <= ce_n | rd_n;
         if (!ce_n && !wr_n)        quiet_cnt <= '0;
         else if (quiet_cnt != 2'd3) quiet_cnt <= quiet_cnt + 2'd1;
      end
   end

   // R5: nothing above the dot field ever reaches the bus
   a_r5_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[DATA_W-1:COLS] == '0);

   // R7: conflicting strobes return nothing
   a_r7_clash_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clash_q |=> rdata == '0);

   // R9: no read strobe, no data
   a_r9_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
      noread_q |=> rdata == '0);

   // R10: unused row code reads zero on the scan port
   a_r10_scan_unused_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_row >= ROW_LIM) |=> scan_dots == '0);

   // R11: steady scan inputs and no writes keep the scan output steady
   a_r11_scan_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_cnt == 2'd3 && $stable(scan_glyph) && $stable(scan_row)) |=> $stable(scan_dots));

endmodule

bind glyph_ram_ctrl glyph_ram_ctrl_chk #(
   .SLOTS(SLOTS), .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W),
   .ADDR_W(ADDR_W), .ROW_SEL_W(ROW_SEL_W)
) u_chk (.*);

// File: tb/glyph_ram_ctrl_tb.sv
`timescale 1ns/1ps
module glyph_ram_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, sel_reg = 1'b0;
   logic [4:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [3:0] scan_glyph = '0;
   logic [2:0] scan_row = '0;
   logic [4:0] scan_dots;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [4:0] exp_mem [16][7];
   logic [3:0] exp_idx;

   always #2 clk = ~clk;

   glyph_ram_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .rd_n(rd_n),
      .sel_reg(sel_reg), .addr(addr), .wdata(wdata), .rdata(rdata),
      .scan_glyph(scan_glyph), .scan_row(scan_row), .scan_dots(scan_dots)
   );

   task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_row_read(input logic [2:0] r);
      return (r == 3'd7) ? 8'h00 : {3'b000, exp_mem[exp_idx][r]};
   endfunction

   function automatic logic [4:0] exp_scan(input logic [3:0] g, input logic [2:0] r);
      return (r == 3'd7) ? 5'd0 : exp_mem[g][r];
   endfunction

   // called at a negedge; returns rdata two edges after the inputs
   task automatic bus(input bit f, input logic [4:0] a, input logic [7:0] d,
                      input bit we, input bit re, output logic [7:0] q);
      sel_reg = f; addr = a; wdata = d;
      ce_n = 1'b0; wr_n = !we; rd_n = !re;
      repeat (2) @(negedge clk);
      q = rdata;
      @(negedge clk);
      ce_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic wr_idx(input logic [7:0] d);
      logic [7:0] q;
      bus(1'b1, 5'b00000, d, 1'b1, 1'b0, q);
      exp_idx = d[3:0];
   endtask

   task automatic wr_row(input logic [2:0] r, input logic [7:0] d);
      logic [7:0] q;
      bus(1'b1, {2'b01, r}, d, 1'b1, 1'b0, q);
      if (r != 3'd7) exp_mem[exp_idx][r] = d[4:0];
   endtask

   task automatic rd_idx(input string req);
      logic [7:0] q;
      bus(1'b1, 5'b00000, 8'h00, 1'b0, 1'b1, q);
      check(q == {4'h0, exp_idx}, req, q, {4'h0, exp_idx});
   endtask

   task automatic rd_row(input logic [2:0] r, input string req);
      logic [7:0] q;
      bus(1'b1, {2'b01, r}, 8'h00, 1'b0, 1'b1, q);
      check(q == exp_row_read(r), req, q, exp_row_read(r));
   endtask

   task automatic scan_chk(input logic [3:0] g, input logic [2:0] r, input string req);
      scan_glyph = g; scan_row = r;
      @(negedge clk);
      check(scan_dots == exp_scan(g, r), req, {3'b0, scan_dots}, {3'b0, exp_scan(g, r)});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] q;
      void'($urandom(32'd4711));
      exp_idx = '0;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(rdata == 8'h00, "R1 rdata in reset", rdata, 8'h00);
      check(scan_dots == 5'd0, "R1 scan_dots in reset", {3'b0, scan_dots}, 8'h00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      rd_idx("R1 index after reset");

      // fill every slot (R5)
      for (int s = 0; s < 16; s++) begin
         wr_idx(8'(s) | 8'($urandom % 16) << 4);
         for (int r = 0; r < 7; r++) wr_row(3'(r), 8'($urandom));
      end
      for (int s = 0; s < 16; s += 5) begin
         wr_idx(8'(s));
         for (int r = 0; r < 8; r++) rd_row(3'(r), "R5/R6 row readback after fill");
      end

      // R3: upper index bits discarded
      wr_idx(8'hA9);
      rd_idx("R3 index keeps low nibble");

      // R5: upper data bits discarded, bit order right-justified
      wr_row(3'd0, 8'hE1);
      rd_row(3'd0, "R5 row keeps low five bits");
      wr_row(3'd6, 8'h10);
      rd_row(3'd6, "R5 seventh row, leftmost column");

      // R6: row code 111 stores nothing and reads zero
      wr_row(3'd7, 8'h1F);
      rd_row(3'd7, "R6 unused row reads zero");
      for (int r = 0; r < 7; r++) rd_row(3'(r), "R6 rows untouched by code 111");

      // R4: undecoded targets
      bus(1'b1, 5'b10000, 8'h05, 1'b1, 1'b0, q);
      bus(1'b1, 5'b11010, 8'h1F, 1'b1, 1'b0, q);
      bus(1'b0, 5'b01010, 8'h0A, 1'b1, 1'b0, q);
      bus(1'b0, 5'b00000, 8'h03, 1'b1, 1'b0, q);
      rd_idx("R4 index unchanged by undecoded writes");
      rd_row(3'd2, "R4 row unchanged by undecoded writes");
      bus(1'b0, 5'b00000, 8'h00, 1'b0, 1'b1, q);
      check(q == 8'h00, "R4 read with sel_reg low", q, 8'h00);
      bus(1'b1, 5'b10010, 8'h00, 1'b0, 1'b1, q);
      check(q == 8'h00, "R4 read of undecoded code", q, 8'h00);

      // R7: clashing strobes
      bus(1'b1, 5'b01011, 8'h0E ^ {3'b0, exp_mem[exp_idx][3]}, 1'b1, 1'b1, q);
      check(q == 8'h00, "R7 clash returns zero", q, 8'h00);
      bus(1'b1, 5'b00000, 8'h07, 1'b1, 1'b1, q);
      rd_idx("R7 index unchanged by clash");
      rd_row(3'd3, "R7 row unchanged by clash");

      // R8: held strobe with changing data writes once
      begin
         logic [4:0] first;
         first = exp_mem[exp_idx][4] ^ 5'h15;
         sel_reg = 1'b1; addr = 5'b01100; wdata = {3'b0, first};
         ce_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1;
         repeat (2) @(negedge clk);
         wdata = {3'b0, ~first};
         repeat (3) @(negedge clk);
         ce_n = 1'b1; wr_n = 1'b1;
         repeat (2) @(negedge clk);
         exp_mem[exp_idx][4] = first;
         rd_row(3'd4, "R8 held strobe wrote only first data");
      end

      // R9: idle bus yields zero
      @(negedge clk);
      check(rdata == 8'h00, "R9 rdata zero when idle", rdata, 8'h00);

      // R12: read latency of two edges
      wr_idx(8'h0B);
      sel_reg = 1'b1; addr = 5'b00000; ce_n = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      check(rdata == 8'h00, "R12 rdata not yet after one edge", rdata, 8'h00);
      @(negedge clk);
      check(rdata == 8'h0B, "R12 rdata after two edges", rdata, 8'h0B);
      ce_n = 1'b1; rd_n = 1'b1;
      repeat (2) @(negedge clk);

      // R10: scan port
      for (int i = 0; i < 20; i++)
         scan_chk(4'($urandom), 3'($urandom), "R10 scan row lookup");
      scan_chk(4'd3, 3'd7, "R10 scan unused row zero");

      // R11: write coinciding with the scan sample shows one edge later
      begin
         logic [4:0] oldv, newv;
         oldv = exp_mem[exp_idx][5];
         newv = ~oldv;
         sel_reg = 1'b1; addr = 5'b01101; wdata = {3'b0, newv};
         ce_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1;
         @(negedge clk);
         scan_glyph = exp_idx; scan_row = 3'd5;
         @(negedge clk);
         check(scan_dots == oldv, "R11 scan on write edge shows old", {3'b0, scan_dots}, {3'b0, oldv});
         @(negedge clk);
         check(scan_dots == newv, "R11 scan one edge later shows new", {3'b0, scan_dots}, {3'b0, newv});
         ce_n = 1'b1; wr_n = 1'b1;
         repeat (2) @(negedge clk);
         exp_mem[exp_idx][5] = newv;
      end

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         case ($urandom % 7)
            0: wr_idx(8'($urandom));
            1: wr_row(3'($urandom), 8'($urandom));
            2: rd_idx("R3 random index read");
            3: rd_row(3'($urandom), "R5 random row read");
            4: begin
                  bus(1'b1, {1'b0, 1'($urandom), 3'($urandom)}, 8'($urandom), 1'b1, 1'b1, q);
                  check(q == 8'h00, "R7 random clash", q, 8'h00);
               end
            5: begin
                  if ($urandom % 2) bus(1'b0, 5'($urandom), 8'($urandom), 1'b1, 1'b0, q);
                  else bus(1'b1, {2'b1 + 2'($urandom % 2) + 2'b1, 3'($urandom)}, 8'($urandom), 1'b1, 1'b0, q);
               end
            default: scan_chk(4'($urandom), 3'($urandom), "R11 random scan");
         endcase
      end
      for (int s = 0; s < 16; s++)
         for (int r = 0; r < 7; r++)
            scan_chk(4'(s), 3'(r), "R4/R7 full sweep after random mix");

      // R2: storage survives reset
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      exp_idx = 4'd0;
      rd_idx("R1 index cleared by reset");
      for (int r = 0; r < 7; r++) rd_row(3'(r), "R2 slot 0 kept over reset");
      scan_chk(4'd9, 3'd2, "R2 scan kept over reset");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule